// File: doc/BRIEF.md
# VGA Raster Timing with Reduced-Resolution Pixel Store

This block produces the raster timing for a 640 by 480 display from one pixel-rate clock (nominally about 25.175 MHz, a period near 40 ns). Two free-running counters track the current column and row. The block drives active-low horizontal and vertical sync from these counters. It also drives three one-bit color levels (red, green, blue), which give eight possible colors.

The color comes from an on-chip pixel store. Holding a full 640 by 480 image would take too much memory, so the column and row counts are shifted right by a power of two before they address the store. Each stored pixel then covers a square of screen pixels. With the default shift of 4, the store holds 40 by 30 entries. The surrounding design updates the image through a synchronous write port on the same clock.

Top module: `vga_lowres_fb`

## Requirements
- R1: The column counter counts 0 to 799 and wraps to 0, so each line lasts H_VIS+H_FP+H_SYNC+H_BP = 800 clocks.
- R2: hsync is low for exactly H_SYNC (96) clocks per line, for the columns from H_VIS+H_FP (656) through 751, and high at all other times.
- R3: The row counter advances only when the column counter wraps, and counts 0 to 524 before it wraps, so a frame lasts 800*525 clocks.
- R4: vsync is low for the rows V_VIS+V_FP (490) and 491 only, and high for all other rows.
- R5: red, green and blue are all 0 whenever the column is 640 or more or the row is 480 or more.
- R6: In the visible area the color shown is the entry at address (row>>SHIFT)*(640>>SHIFT) + (col>>SHIFT). Stored data bit 2 is red, bit 1 is green and bit 0 is blue.
- R7: Every output appears one clock after its counter position, so sync, blanking and color stay aligned.
- R8: When wr_en is high, wr_data is stored at wr_addr on the clock edge. This works during reset too. If a write and a read hit the same address on the same edge, the output shows the old data.
- R9: While rst_n is low, both counters are held at 0, hsync and vsync are 1, and all colors are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Pixel store write enable |
| wr_addr | input | AW | Pixel store write address |
| wr_data | input | 3 | Color to store: bit 2 red, bit 1 green, bit 0 blue |
| hsync | output | 1 | Horizontal sync, active low |
| vsync | output | 1 | Vertical sync, active low |
| red | output | 1 | Red level |
| green | output | 1 | Green level |
| blue | output | 1 | Blue level |

## Verification
The bench first fills the store with an address-derived pattern while reset is held. This makes every visible color predictable and shows whether addresses are decoded correctly across block boundaries. It then runs two full frames with scattered random writes. This separates writes that land before a read from writes that are missed. Some of these writes are aimed at the address being read on that very edge. They show whether the old or the new data reaches the output. The time between falling sync edges is measured to separate a wrong period from a wrong pulse position. Timing is scaled down through the parameters so that several frames fit in the run.

// File: rtl/vga_lowres_fb.sv
module vga_lowres_fb #(
  parameter int H_VIS  = 640,
  parameter int H_FP   = 16,
  parameter int H_SYNC = 96,
  parameter int H_BP   = 48,
  parameter int V_VIS  = 480,
  parameter int V_FP   = 10,
  parameter int V_SYNC = 2,
  parameter int V_BP   = 33,
  parameter int SHIFT  = 4,
  localparam int H_TOT = H_VIS + H_FP + H_SYNC + H_BP,
  localparam int V_TOT = V_VIS + V_FP + V_SYNC + V_BP,
  localparam int FB_W  = H_VIS >> SHIFT,
  localparam int FB_H  = V_VIS >> SHIFT,
  localparam int FB_N  = FB_W * FB_H,
  localparam int AW    = $clog2(FB_N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [2:0]    wr_data,
  output logic          hsync,
  output logic          vsync,
  output logic          red,
  output logic          green,
  output logic          blue
);
  localparam int HW = $clog2(H_TOT);
  localparam int VW = $clog2(V_TOT);
  localparam logic [HW-1:0] H_LAST = HW'(H_TOT - 1);
  localparam logic [HW-1:0] H_VEND = HW'(H_VIS);
  localparam logic [HW-1:0] H_S0   = HW'(H_VIS + H_FP);
  localparam logic [HW-1:0] H_S1   = HW'(H_VIS + H_FP + H_SYNC);
  localparam logic [VW-1:0] V_LAST = VW'(V_TOT - 1);
  localparam logic [VW-1:0] V_VEND = VW'(V_VIS);
  localparam logic [VW-1:0] V_S0   = VW'(V_VIS + V_FP);
  localparam logic [VW-1:0] V_S1   = VW'(V_VIS + V_FP + V_SYNC);
  localparam logic [AW-1:0] FBW_A  = AW'(FB_W);

  logic [HW-1:0] hcnt;
  logic [VW-1:0] vcnt;
  logic [2:0]    mem [FB_N];
  logic [2:0]    pix_q;
  logic          hs_q, vs_q, vis_q;

  wire line_end = (hcnt == H_LAST);
  wire visible  = (hcnt < H_VEND) && (vcnt < V_VEND);
  wire [AW-1:0] rd_addr = AW'(vcnt >> SHIFT) * FBW_A + AW'(hcnt >> SHIFT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt <= '0;
      vcnt <= '0;
    end else begin
      hcnt <= line_end ? '0 : hcnt + 1'b1;
      if (line_end) vcnt <= (vcnt == V_LAST) ? '0 : vcnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q  <= 1'b1;
      vs_q  <= 1'b1;
      vis_q <= 1'b0;
    end else begin
      hs_q  <= !(hcnt >= H_S0 && hcnt < H_S1);
      vs_q  <= !(vcnt >= V_S0 && vcnt < V_S1);
      vis_q <= visible;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (visible) pix_q <= mem[rd_addr];
  end

  assign hsync = hs_q;
  assign vsync = vs_q;
  assign red   = vis_q & pix_q[2];
  assign green = vis_q & pix_q[1];
  assign blue  = vis_q & pix_q[0];

  assert_line_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    line_end |=> hcnt == '0);
  assert_col_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    hcnt <= H_LAST);
  assert_row_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !line_end |=> $stable(vcnt));
  assert_row_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    vcnt <= V_LAST);
  assert_dark_in_hsync_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !hsync |-> !(red | green | blue));
  assert_dark_in_vsync_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !vsync |-> !(red | green | blue));
endmodule

// File: tb/vga_lowres_fb_tb.sv
module vga_lowres_fb_tb;
  localparam int HV = 64, HF = 4, HS = 8, HB = 4;
  localparam int VV = 48, VF = 2, VS = 2, VB = 3;
  localparam int SH = 2;
  localparam int HT = HV + HF + HS + HB;
  localparam int VT = VV + VF + VS + VB;
  localparam int FW = HV >> SH;
  localparam int FN = FW * (VV >> SH);
  localparam int AW = $clog2(FN);

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [2:0] wr_data = '0;
  logic hsync, vsync, red, green, blue;

  vga_lowres_fb #(.H_VIS(HV), .H_FP(HF), .H_SYNC(HS), .H_BP(HB),
                  .V_VIS(VV), .V_FP(VF), .V_SYNC(VS), .V_BP(VB), .SHIFT(SH))
    u_dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
           .wr_data(wr_data), .hsync(hsync), .vsync(vsync),
           .red(red), .green(green), .blue(blue));

  always #4 clk = ~clk;

  int total = 0, bad = 0;
  int h = 0, v = 0;
  logic [2:0] mm [FN];
  logic e_hs = 1, e_vs = 1, coll = 0;
  logic [2:0] e_rgb = 0;

  function automatic int addr_of(int c, int r);
    return (r >> SH) * FW + (c >> SH);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      h = 0; v = 0; e_hs = 1; e_vs = 1; e_rgb = 0; coll = 0;
    end else begin
      automatic bit vis = (h < HV) && (v < VV);
      automatic int a = addr_of(h, v);
      e_hs = !(h >= HV + HF && h < HV + HF + HS);
      e_vs = !(v >= VV + VF && v < VV + VF + VS);
      e_rgb = vis ? mm[a] : 3'b000;
      coll = wr_en && vis && (int'(wr_addr) == a) && (mm[a] != wr_data);
      if (h == HT - 1) begin h = 0; v = (v == VT - 1) ? 0 : v + 1; end
      else h = h + 1;
    end
    if (wr_en) mm[wr_addr] = wr_data;
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  initial begin
    int last_hf, last_vf, cyc;
    logic p_hs, p_vs;
    last_hf = -1; last_vf = -1; cyc = 0; p_hs = 1; p_vs = 1;
    for (int i = 0; i < FN; i++) begin
      @(negedge clk);
      wr_en = 1; wr_addr = AW'(i); wr_data = 3'(i * 5 + 3);
    end
    @(negedge clk);
    wr_en = 0;
    chk(hsync == 1 && vsync == 1 && {red, green, blue} == 0, "R9 reset state",
        int'({hsync, vsync, red, green, blue}), 24);
    rst_n = 1;
    @(negedge clk);
    chk({red, green, blue} == e_rgb && e_rgb == mm[0], "R7 first pixel aligned",
        int'({red, green, blue}), int'(e_rgb));
    for (int k = 0; k < 2 * HT * VT + 200; k++) begin
      wr_en = 0;
      if ($urandom % 4 == 0) begin
        wr_en = 1;
        wr_data = 3'($urandom);
        if ($urandom % 2 == 0 && h < HV && v < VV) wr_addr = AW'(addr_of(h, v));
        else wr_addr = AW'($urandom % FN);
      end
      @(negedge clk);
      cyc++;
      chk(hsync == e_hs, "R2 hsync", int'(hsync), int'(e_hs));
      chk(vsync == e_vs, "R4 vsync", int'(vsync), int'(e_vs));
      if (e_rgb == 0 && (e_hs == 0 || e_vs == 0))
        chk({red, green, blue} == 0, "R5 blank", int'({red, green, blue}), 0);
      else if (coll)
        chk({red, green, blue} == e_rgb, "R8 read old on collision",
            int'({red, green, blue}), int'(e_rgb));
      else
        chk({red, green, blue} == e_rgb, "R6 pixel color",
            int'({red, green, blue}), int'(e_rgb));
      if (p_hs && !hsync) begin
        if (last_hf >= 0) chk(cyc - last_hf == HT, "R1 line period", cyc - last_hf, HT);
        last_hf = cyc;
      end
      if (p_vs && !vsync) begin
        if (last_vf >= 0) chk(cyc - last_vf == HT * VT, "R3 frame period",
                              cyc - last_vf, HT * VT);
        last_vf = cyc;
      end
      p_hs = hsync; p_vs = vsync;
    end
    wr_en = 0;
    rst_n = 0;
    #1;
    chk(hsync == 1 && vsync == 1 && {red, green, blue} == 0, "R9 reset again",
        int'({hsync, vsync, red, green, blue}), 24);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule